// File: doc/BRIEF.md
# 64-bit Operating-System Timer with Snapshot Read

This block keeps a 64-bit up-counter for an operating system. The counter advances on a tick. The tick comes from the block's own clock, from a slow real-time strobe or from an external strobe, and a power-of-four prescaler then divides it. Software sees the counter as two 32-bit words, a 32-bit compare word and a control word. When the low word equals the compare value on a counting step, a sticky flag is set and the interrupt line rises. The counter then either returns to zero, which gives a periodic tick, or keeps running, which gives a timestamp source.

Reading a 64-bit value through a 32-bit access can tear. To prevent this, every read of the low word copies the high word into a separate snapshot register, and software reads that register afterwards. The timer runs only when its enable bit is set and the halt bit in the control word is clear. The enable bit is changed through a write-one-to-set address and a write-one-to-clear address.

Top module: `ostmr_top`

## Requirements
- R1: After a synchronous active-low reset, every readable word (compare 0x00, low 0x04, high 0x08, control 0x0C, enable status 0x10, snapshot 0x1C, flag 0x20) reads zero and `irq` is low.
- R2: Compare and control are writable and read back. Control keeps only bit 0 (clock source), bit 1 (real-time strobe), bit 2 (external strobe), bits 5:3 (prescale), bit 9 (halt) and bit 15 (free-run), so writing all ones reads back 0x0000823F.
- R3: Writing a word with bit 15 set to 0x14 sets the enable bit, and writing it to 0x18 clears it. Written zeros change nothing. Enable status reads at 0x10 bit 15.
- R4: With the clock source selected and prescale 0, the counter rises by exactly one per clock while running. A carry out of the low word increments the high word.
- R5: Prescale code n divides ticks by 4^n (0 gives 1, 1 gives 4, 5 gives 1024). Codes 6 and 7 divide by 1024. A control write restarts the prescaler.
- R6: With a strobe source selected and the clock source clear, the counter advances once per one-cycle pulse of that strobe and ignores the other clock cycles.
- R7: In clear mode (bit 15 = 0), a step taken while the low word equals compare loads zero into all 64 bits.
- R8: In free-run mode (bit 15 = 1), a step taken at a match still increments the counter.
- R9: A step taken at a match sets the flag (0x20 bit 0), and `irq` follows the flag. Writing 1 to bit 0 clears it, and writing 0 leaves it set.
- R10: A read of 0x04 copies the high word into the snapshot register (0x1C). Later writes to the high word leave the snapshot unchanged until the next read of 0x04.
- R11: While halt is set or enable is clear, the counter and prescaler hold their values.
- R12: Writes to 0x04 and 0x08 load the corresponding counter word directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the clock tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick | input | 1 | One-cycle strobe from the real-time source |
| ext_tick | input | 1 | One-cycle strobe from the external source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Compare-match interrupt, level |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so the bench samples it one time unit after driving the address at a falling edge. A counting step lands on the edge after the tick that completes the prescale count. The enable write at one edge therefore first counts on the next edge, and a run from an enable write to a disable write k edges later gives exactly k ticks. The bench brackets every counting scenario this way and reads the counter only after it stops. The flag and `irq` are registered and are checked at the falling edge after the step that matched. The snapshot is loaded at the edge that ends the low-word read, so the bench reads it with a later access.

// File: rtl/ostmr_pkg.sv
// Package: shared register offsets, control field positions and the
// control word type for the operating-system timer.
package ostmr_pkg;

    localparam logic [5:0] A_CMP   = 6'h00;
    localparam logic [5:0] A_CLO   = 6'h04;
    localparam logic [5:0] A_CHI   = 6'h08;
    localparam logic [5:0] A_CTL   = 6'h0C;
    localparam logic [5:0] A_ENST  = 6'h10;
    localparam logic [5:0] A_ENSET = 6'h14;
    localparam logic [5:0] A_ENCLR = 6'h18;
    localparam logic [5:0] A_SHD   = 6'h1C;
    localparam logic [5:0] A_FLAG  = 6'h20;

    localparam int B_PCK  = 0;
    localparam int B_RTC  = 1;
    localparam int B_EXT  = 2;
    localparam int B_PRE  = 3;
    localparam int B_HALT = 9;
    localparam int B_FREE = 15;
    localparam int B_RUN  = 15;

    localparam int PRE_MAX_CODE = 5;

    typedef struct packed {
        logic       free;
        logic       halt;
        logic [2:0] pre;
        logic       ext_en;
        logic       rtc_en;
        logic       pck_en;
    } ctl_t;

endpackage

// File: rtl/ostmr_regs.sv
// Register file: holds compare, control, run-enable and the sticky match
// flag, decodes write strobes for the counter words and muxes read data.
// Assumes single-cycle strobes and word-aligned addresses.
module ostmr_regs
    import ostmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_lo,
    input  logic [DATA_W-1:0] cnt_hi,
    input  logic [DATA_W-1:0] shadow,
    input  logic              flag_set,
    output logic [DATA_W-1:0] cmp,
    output ctl_t              ctl,
    output logic              en,
    output logic              flag,
    output logic              ctl_wr,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              rd_lo,
    output logic [DATA_W-1:0] rdata
);

    logic wr_cmp, wr_set, wr_clr, wr_flag;

    // Address decode of the write and read strobes.
    always_comb begin
        wr_cmp  = wr && (addr == ADDR_W'(A_CMP));
        ctl_wr  = wr && (addr == ADDR_W'(A_CTL));
        wr_lo   = wr && (addr == ADDR_W'(A_CLO));
        wr_hi   = wr && (addr == ADDR_W'(A_CHI));
        wr_set  = wr && (addr == ADDR_W'(A_ENSET));
        wr_clr  = wr && (addr == ADDR_W'(A_ENCLR));
        wr_flag = wr && (addr == ADDR_W'(A_FLAG));
        rd_lo   = rd && (addr == ADDR_W'(A_CLO));
    end

    // Compare and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
            ctl <= '0;
        end else begin
            if (wr_cmp) cmp <= wdata;
            if (ctl_wr) begin
                ctl.free   <= wdata[B_FREE];
                ctl.halt   <= wdata[B_HALT];
                ctl.pre    <= wdata[B_PRE+2:B_PRE];
                ctl.ext_en <= wdata[B_EXT];
                ctl.rtc_en <= wdata[B_RTC];
                ctl.pck_en <= wdata[B_PCK];
            end
        end
    end

    // Run-enable bit, set and cleared only by written ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                     en <= 1'b0;
        else if (wr_set && wdata[B_RUN]) en <= 1'b1;
        else if (wr_clr && wdata[B_RUN]) en <= 1'b0;
    end

    // Sticky match flag; a new match wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (flag_set)           flag <= 1'b1;
        else if (wr_flag && wdata[0]) flag <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CMP):  rdata = cmp;
            ADDR_W'(A_CLO):  rdata = cnt_lo;
            ADDR_W'(A_CHI):  rdata = cnt_hi;
            ADDR_W'(A_CTL): begin
                rdata[B_PCK]           = ctl.pck_en;
                rdata[B_RTC]           = ctl.rtc_en;
                rdata[B_EXT]           = ctl.ext_en;
                rdata[B_PRE+2:B_PRE]   = ctl.pre;
                rdata[B_HALT]          = ctl.halt;
                rdata[B_FREE]          = ctl.free;
            end
            ADDR_W'(A_ENST): rdata[B_RUN] = en;
            ADDR_W'(A_SHD):  rdata = shadow;
            ADDR_W'(A_FLAG): rdata[0] = flag;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/ostmr_tick.sv
// Tick source and prescaler: merges the enabled tick sources and divides
// them by a power of four. Assumes strobes are already synchronous to clk
// and last one cycle. Holds its count whenever run is low.
module ostmr_tick #(
    parameter int NSRC  = 3,
    parameter int PRE_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_in,
    input  logic [2:0]      pre_sel,
    output logic            step
);

    localparam int MAX_CODE = PRE_W / 2;

    logic [NSRC-1:0]  src_hit;
    logic             tick;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_cnt;

    // Gate each source with its enable bit.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_hit[g] = src_en[g] & src_in[g];
    end

    // Raw tick and terminal count of the selected division.
    always_comb begin
        int code;
        tick  = run && (|src_hit);
        code  = (int'(pre_sel) > MAX_CODE) ? MAX_CODE : int'(pre_sel);
        limit = PRE_W'((32'd1 << (2 * code)) - 32'd1);
        step  = tick && (pre_cnt >= limit);
    end

    // Prescale counter, restarted on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_cnt <= '0;
        else if (tick)         pre_cnt <= (pre_cnt >= limit) ? '0 : pre_cnt + 1'b1;
    end

endmodule

// File: rtl/ostmr_count.sv
// Counter core: 64-bit up-counter with a low-word compare, clear or
// free-run behaviour on match, direct word loads and the high-word
// snapshot taken on a low-word read. A software load wins over a step.
module ostmr_count #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                free,
    input  logic [HALF_W-1:0]   cmp,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                rd_lo,
    output logic [2*HALF_W-1:0] cnt,
    output logic [HALF_W-1:0]   shadow,
    output logic                match_evt
);

    localparam int CNT_W = 2 * HALF_W;

    logic hit;

    // Low-word equality and the resulting match event.
    always_comb begin
        hit       = (cnt[HALF_W-1:0] == cmp);
        match_evt = step && hit;
    end

    // Counter update: step first, then software loads override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            if (step) begin
                if (hit && !free) cnt <= '0;
                else              cnt <= cnt + CNT_W'(1);
            end
            if (wr_lo) cnt[HALF_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:HALF_W] <= wdata;
        end
    end

    // Snapshot of the high word on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (rd_lo) shadow <= cnt[CNT_W-1:HALF_W];
    end

endmodule

// File: rtl/ostmr_top.sv
// Top of the operating-system timer: ties register file, tick/prescaler
// and counter core together. Assumes a simple strobe register port and
// tick strobes already in the clk domain.
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int PRE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              ext_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int NSRC  = 3;

    ctl_t              ctl;
    logic [DATA_W-1:0] cmp;
    logic              en, flag, ctl_wr, wr_lo, wr_hi, rd_lo;
    logic              run, step, match_evt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shadow;
    logic [NSRC-1:0]   src_en, src_in;

    // Run qualifier and source vectors.
    always_comb begin
        run    = en && !ctl.halt;
        src_en = {ctl.ext_en, ctl.rtc_en, ctl.pck_en};
        src_in = {ext_tick, rtc_tick, 1'b1};
        irq    = flag;
    end

    ostmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata),
        .cnt_lo(cnt[DATA_W-1:0]), .cnt_hi(cnt[CNT_W-1:DATA_W]),
        .shadow(shadow), .flag_set(match_evt),
        .cmp(cmp), .ctl(ctl), .en(en), .flag(flag), .ctl_wr(ctl_wr),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rdata(bus_rdata)
    );

    ostmr_tick #(.NSRC(NSRC), .PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(ctl_wr),
        .src_en(src_en), .src_in(src_in), .pre_sel(ctl.pre), .step(step)
    );

    ostmr_count #(.HALF_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(step), .free(ctl.free),
        .cmp(cmp), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
        .rd_lo(rd_lo), .cnt(cnt), .shadow(shadow), .match_evt(match_evt)
    );

endmodule

// File: rtl/ostmr_checker.sv
// Checker: temporal properties of the timer, bound onto ostmr_top.
module ostmr_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             step,
    input logic             free,
    input logic             match_evt,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             rd_lo,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W/2-1:0] shadow,
    input logic             irq
);

    localparam int HALF = CNT_W / 2;

    assert_hold_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

    assert_snapshot_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow == $past(cnt[CNT_W-1:HALF])));

    assert_clear_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !free && !wr_lo && !wr_hi) |=> (cnt == '0));

    assert_match_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> irq);

    assert_step_increments_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(match_evt && !free) && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 1'b1));

endmodule

bind ostmr_top ostmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .free(ctl.free),
    .match_evt(match_evt), .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo),
    .cnt(cnt), .shadow(shadow), .irq(irq)
);

// File: tb/ostmr_top_bench.sv
// Directed bench for ostmr_top: one task per scenario.
module ostmr_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0, ext_tick = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    ostmr_top u_ostmr_top (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; write lands on the next rising edge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run the timer for exactly k clock ticks.
    task automatic run_for(input int k);
        wr(6'h14, 32'h8000);
        if (k > 1) idle(k - 1);
        wr(6'h18, 32'h8000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (u_addrs[i]) begin
            rd(u_addrs[i], v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);
    endtask

    logic [5:0] u_addrs [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h1C, 6'h20};

    task automatic t_regs();
        logic [31:0] v;
        wr(6'h00, 32'hA5A5_1234); rd(6'h00, v);
        check("R2 compare readback", v, 32'hA5A5_1234);
        wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v);
        check("R2 control mask", v, 32'h0000_823F);
        wr(6'h0C, 32'h0); rd(6'h0C, v);
        check("R2 control cleared", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(6'h0C, 32'h0000_0200);          // halted so nothing counts
        wr(6'h14, 32'h8000); rd(6'h10, v);
        check("R3 set enable", v, 32'h8000);
        wr(6'h14, 32'h0); wr(6'h18, 32'h7FFF); rd(6'h10, v);
        check("R3 zeros ignored", v, 32'h8000);
        wr(6'h18, 32'h8000); rd(6'h10, v);
        check("R3 clear enable", v, 32'h0);
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        wr(6'h08, hi); wr(6'h04, lo);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_0000);
        wr(6'h0C, 32'h0000_8001);
        load(32'h0, 32'h0);
        run_for(17); rd(6'h04, v);
        check("R4 one per clock", v, 32'd17);
        load(32'h1, 32'hFFFF_FFFF);
        run_for(1); rd(6'h04, v);
        check("R4 carry low", v, 32'h0);
        rd(6'h08, v);
        check("R4 carry high", v, 32'h2);
        load(32'h0, 32'h10); rd(6'h04, v);
        check("R12 direct load", v, 32'h10);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_0000);
        wr(6'h0C, 32'h0000_8009);          // div 4
        load(32'h0, 32'h0);
        run_for(40); rd(6'h04, v);
        check("R5 divide by 4", v, 32'd10);
        wr(6'h0C, 32'h0000_8029);          // div 1024
        load(32'h0, 32'h0);
        run_for(3000); rd(6'h04, v);
        check("R5 divide by 1024", v, 32'd2);
        wr(6'h0C, 32'h0000_8019);          // div 64
        load(32'h0, 32'h0);
        run_for(63); rd(6'h04, v);
        check("R5 divide by 64 short", v, 32'd0);
    endtask

    task automatic t_strobe();
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_0000);
        wr(6'h0C, 32'h0000_8002);          // real-time strobe only
        load(32'h0, 32'h0);
        wr(6'h14, 32'h8000);
        repeat (5) begin
            rtc_tick = 1'b1; ext_tick = 1'b1; @(negedge clk);
            rtc_tick = 1'b0; ext_tick = 1'b0; idle(2);
        end
        wr(6'h18, 32'h8000); rd(6'h04, v);
        check("R6 real-time pulses", v, 32'd5);
        wr(6'h0C, 32'h0000_8004);          // external strobe only
        load(32'h0, 32'h0);
        wr(6'h14, 32'h8000);
        repeat (3) begin
            ext_tick = 1'b1; @(negedge clk);
            ext_tick = 1'b0; rtc_tick = 1'b1; @(negedge clk);
            rtc_tick = 1'b0;
        end
        wr(6'h18, 32'h8000); rd(6'h04, v);
        check("R6 external pulses", v, 32'd3);
    endtask

    task automatic t_clear_mode();
        logic [31:0] v;
        wr(6'h00, 32'd5);
        wr(6'h0C, 32'h0000_0001);
        load(32'h7, 32'h0);
        wr(6'h20, 32'h1);
        run_for(3); rd(6'h04, v);
        check("R7 before match", v, 32'd3);
        check("R9 no irq before match", {31'b0, irq}, 32'h0);
        run_for(3); rd(6'h04, v);
        check("R7 wrapped low", v, 32'h0);
        rd(6'h08, v);
        check("R7 wrapped high", v, 32'h0);
        check("R9 irq on match", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_free_mode();
        logic [31:0] v;
        wr(6'h20, 32'h1);
        check("R9 flag cleared", {31'b0, irq}, 32'h0);
        wr(6'h00, 32'd5);
        wr(6'h0C, 32'h0000_8001);
        load(32'h0, 32'h0);
        run_for(8); rd(6'h04, v);
        check("R8 passes match", v, 32'd8);
        rd(6'h20, v);
        check("R9 flag read", v, 32'h1);
        wr(6'h20, 32'h0);
        check("R9 zero write keeps flag", {31'b0, irq}, 32'h1);
        wr(6'h20, 32'h1);
        check("R9 one write clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_snapshot();
        logic [31:0] v;
        load(32'h12, 32'h99);
        rd(6'h04, v);
        rd(6'h1C, v);
        check("R10 snapshot taken", v, 32'h12);
        wr(6'h08, 32'h34); rd(6'h1C, v);
        check("R10 snapshot held", v, 32'h12);
        rd(6'h04, v); rd(6'h1C, v);
        check("R10 snapshot refreshed", v, 32'h34);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_0000);
        wr(6'h0C, 32'h0000_8201);
        load(32'h0, 32'h0);
        run_for(20); rd(6'h04, v);
        check("R11 halt holds", v, 32'h0);
        wr(6'h0C, 32'h0000_8001);
        idle(10); rd(6'h04, v);
        check("R11 disabled holds", v, 32'h0);
        wr(6'h0C, 32'h0000_8009);          // div 4, partial count then halt
        run_for(2);
        wr(6'h0C, 32'h0000_8209);          // halt write restarts prescaler too
        wr(6'h14, 32'h8000); idle(5); wr(6'h18, 32'h8000);
        rd(6'h04, v);
        check("R11 prescaler held", v, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_enable();
        t_count();
        t_prescale();
        t_strobe();
        t_clear_mode();
        t_free_mode();
        t_snapshot();
        t_halt();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule